// File: doc/BRIEF.md
# I2C Bus Slave Address and Status Unit

This block is the bus-facing slave end of a two-wire serial interface. It watches the clock and data lines, which arrive already synchronised to the system clock. It finds START and STOP conditions and shifts in the first byte after each START. It then decides whether the master is talking to it: either the 7-bit address equals the programmed own address, or the byte is the all-zero general-call address and acknowledge generation is on. When the slave is addressed and acknowledge generation is enabled, it pulls the data line low for the ninth clock of every byte it receives.

A CPU reads and writes two 8-bit registers through a simple port. The first is a control and status register. Its upper three bits are control bits the CPU can write. Its lower five bits are flags that bus events set and clear: general call seen, transfer direction, bus busy, address matched, and the value of the last ninth bit. The second register holds the own address. An internal interrupt flag rises at the end of each acknowledge phase while the slave is addressed. The interrupt-flag enable bit gates it, and any CPU write to the control register clears it. The interrupt output also needs a global enable input. A slave that is not addressed ignores the bus until the next START.

Top module: `i2c_slave_stat`

## Requirements
- R1: After reset, both registers read 00h, and irq_o and sda_oe_o are 0.
- R2: Register select 0 is the control/status register. Bit 7 enables acknowledge, bit 6 enables the module, bit 5 enables the interrupt flag, bit 4 is general call, bit 3 is direction, bit 2 is busy, bit 1 is address match and bit 0 is the last ninth bit. Bits 7:5 are read/write and writes do not change bits 4:0. Register select 1 is the own address, which is read/write and whose bits 6:0 are compared.
- R3: A START (SDA falls while SCL is high) sets the busy bit. A STOP (SDA rises while SCL is high) clears it.
- R4: The address-match bit is set when the first 7 received bits, MSB first, equal own address bits 6:0. START and STOP clear it.
- R5: The general-call bit is set when those 7 bits are all zero. START and STOP clear it.
- R6: When the slave is addressed, the direction bit takes the eighth bit of the address byte (1 means slave transmit). START clears it.
- R7: When the slave is addressed and acknowledge is enabled, sda_oe_o is 1 from the SCL fall after the eighth bit to the SCL fall after the ninth bit. This applies to the address byte and to data bytes in receive direction. With acknowledge disabled the slave never drives SDA.
- R8: While the slave is addressed, the last-bit flag takes the SDA value at the ninth SCL rise (0 means ACK, 1 means no ACK).
- R9: The interrupt flag intf_o is set at the SCL fall that ends the ninth clock of an addressed byte, but only when bit 5 is 1. Any write to register 0 clears it. irq_o is 1 only when intf_o, bit 5 and irq_gate_i are all 1.
- R10: With the module-enable bit at 0, bus conditions and bits are ignored: busy is not set and the slave never drives SDA.
- R11: The slave is addressed by the general-call address only when acknowledge is enabled. A slave that is not addressed does not acknowledge and raises no interrupt flag until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA (bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_sel_i | input | 1 | 0 control/status, 1 own address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of selected register |
| irq_gate_i | input | 1 | Global interrupt enable |
| intf_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong state in the byte engine shows up within one byte time. A bit counter that is off by one makes the acknowledge pulse appear one SCL period early or late. A wrong address decision shows as a missing or unexpected low on SDA at the ninth clock, and as a wrong match or general-call bit read right after it. Flag clearing errors become visible at the first STOP or START, where the busy, match and general-call bits must all read back as cleared. Interrupt gating faults show on irq_o as soon as the ninth clock ends.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 7;
  localparam int unsigned CNT_W  = $clog2(DW + 2);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_IGN  = 2'd3
  } eng_st_e;

  // control/status bit positions
  localparam int unsigned B_ACKE = 7;
  localparam int unsigned B_EN   = 6;
  localparam int unsigned B_IEN  = 5;
  localparam int unsigned B_GC   = 4;
  localparam int unsigned B_TR   = 3;
  localparam int unsigned B_BUSY = 2;
  localparam int unsigned B_SAM  = 1;
  localparam int unsigned B_LRB  = 0;
endpackage

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADR_W  = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              acke_i,
  input  logic [DATA_W-1:0] own_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic              sda_oe_o,
  output logic              if_set_o,
  output logic              gc_o,
  output logic              tr_o,
  output logic              busy_o,
  output logic              sam_o,
  output logic              lrb_o
);
  localparam int unsigned CW      = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] LAST  = CW'(DATA_W);
  localparam logic [CW-1:0] RWBIT = CW'(DATA_W - 1);

  eng_st_e          st_q;
  logic [CW-1:0]    cnt_q;
  logic [ADR_W-1:0] sh_q;
  logic             nine_q;
  logic             match, gcall, addr_ok, rx_dir;

  assign match   = (sh_q == own_i[ADR_W-1:0]);
  assign gcall   = (sh_q == '0);
  assign addr_ok = match | (gcall & acke_i);
  assign rx_dir  = (st_q == ST_ADDR) | ((st_q == ST_DATA) & ~tr_o);
  assign if_set_o = en_i & ~start_i & ~stop_i & scl_fall_i & nine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      nine_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      gc_o     <= 1'b0;
      tr_o     <= 1'b0;
      busy_o   <= 1'b0;
      sam_o    <= 1'b0;
      lrb_o    <= 1'b0;
    end else if (!en_i) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      nine_q   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      nine_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b1;
      sam_o    <= 1'b0;
      gc_o     <= 1'b0;
      tr_o     <= 1'b0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      nine_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      sam_o    <= 1'b0;
      gc_o     <= 1'b0;
    end else begin
      if (!acke_i) sda_oe_o <= 1'b0;
      if (scl_rise_i && (st_q == ST_ADDR || st_q == ST_DATA)) begin
        if (cnt_q == LAST) begin
          lrb_o  <= sda_i;
          cnt_q  <= '0;
          nine_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (st_q == ST_ADDR && cnt_q == RWBIT) begin
            // sh_q holds the full address at this point
            sam_o <= match;
            gc_o  <= gcall;
            tr_o  <= addr_ok & sda_i;
            if (!addr_ok) st_q <= ST_IGN;
          end else begin
            sh_q <= {sh_q[ADR_W-2:0], sda_i};
          end
        end
      end
      if (scl_fall_i) begin
        if (nine_q) begin
          nine_q   <= 1'b0;
          sda_oe_o <= 1'b0;
          if (st_q == ST_ADDR) st_q <= ST_DATA;
        end else if (cnt_q == LAST && acke_i && rx_dir) begin
          sda_oe_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int unsigned DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [4:0]        flags_i,
  input  logic              if_set_i,
  input  logic              gate_i,
  output logic              acke_o,
  output logic              en_o,
  output logic              ien_o,
  output logic [DATA_W-1:0] own_o,
  output logic              intf_o,
  output logic              irq_o
);
  logic [2:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      own_o  <= '0;
      intf_o <= 1'b0;
    end else begin
      if (we_i && !sel_i) begin
        ctl_q  <= wdata_i[B_ACKE:B_IEN];
        intf_o <= 1'b0;
      end else if (if_set_i && ien_o) begin
        intf_o <= 1'b1;
      end
      if (we_i && sel_i) own_o <= wdata_i;
    end
  end

  assign acke_o  = ctl_q[2];
  assign en_o    = ctl_q[1];
  assign ien_o   = ctl_q[0];
  assign rdata_o = sel_i ? own_o : {ctl_q, flags_i};
  assign irq_o   = intf_o & ien_o & gate_i;
endmodule

// File: rtl/i2c_slave_stat.sv
module i2c_slave_stat
  import i2cs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          reg_sel_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          irq_gate_i,
  output logic          intf_o,
  output logic          irq_o
);
  logic start_w, stop_w, rise_w, fall_w;
  logic acke_w, en_w, ien_w, if_set_w;
  logic gc_w, tr_w, busy_w, sam_w, lrb_w;
  logic [DW-1:0] own_w;

  i2cs_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_w), .stop_o(stop_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w)
  );

  i2cs_engine #(.DATA_W(DW), .ADR_W(AW)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .acke_i(acke_w), .own_i(own_w),
    .sda_i(sda_i), .start_i(start_w), .stop_i(stop_w), .scl_rise_i(rise_w),
    .scl_fall_i(fall_w), .sda_oe_o(sda_oe_o), .if_set_o(if_set_w), .gc_o(gc_w),
    .tr_o(tr_w), .busy_o(busy_w), .sam_o(sam_w), .lrb_o(lrb_w)
  );

  i2cs_regs #(.DATA_W(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(reg_sel_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .flags_i({gc_w, tr_w, busy_w, sam_w, lrb_w}), .if_set_i(if_set_w),
    .gate_i(irq_gate_i), .acke_o(acke_w), .en_o(en_w), .ien_o(ien_w),
    .own_o(own_w), .intf_o(intf_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic intf_o,
  input logic acke_w,
  input logic en_w,
  input logic start_w,
  input logic stop_w,
  input logic busy_w,
  input logic sam_w,
  input logic gc_w
);
  assert_busy_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && start_w) |=> busy_w);

  assert_stop_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && stop_w) |=> (!busy_w && !sam_w && !gc_w));

  assert_start_clears_gc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && start_w) |=> (!gc_w && !sam_w));

  assert_oe_on_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_i));

  assert_oe_needs_acke_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> $past(acke_w));

  assert_intf_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intf_o) |-> !$past(scl_i));

  assert_quiet_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> !sda_oe_o);
endmodule

bind i2c_slave_stat i2cs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .intf_o(intf_o), .acke_w(acke_w), .en_w(en_w), .start_w(start_w),
  .stop_w(stop_w), .busy_w(busy_w), .sam_w(sam_w), .gc_w(gc_w)
);

// File: tb/i2c_slave_stat_tb.sv
`timescale 1ns/1ps
module i2c_slave_stat_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe;
  logic sel = 1'b0, we = 1'b0, gate = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic intf, irq;
  int checks = 0, errors = 0;
  logic ack_seen;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_slave_stat u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_gate_i(gate), .intf_o(intf), .irq_o(irq)
  );

  // {own, acke, addr byte, exp_sam, exp_gc, exp_ack}
  localparam logic [19:0] VEC [8] = '{
    {8'h42, 1'b1, 8'h84, 3'b101},
    {8'h42, 1'b1, 8'h85, 3'b101},
    {8'h42, 1'b1, 8'h86, 3'b000},
    {8'h42, 1'b0, 8'h84, 3'b100},
    {8'h00, 1'b1, 8'h00, 3'b111},
    {8'h42, 1'b1, 8'h00, 3'b011},
    {8'h42, 1'b0, 8'h00, 3'b010},
    {8'h7F, 1'b1, 8'hFE, 3'b101}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); sel = s; #1 d = rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; cyc(4);
    sda_m = 1'b0; cyc(4);
    scl_m = 1'b0; cyc(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(4);
    scl_m = 1'b1; cyc(4);
    sda_m = 1'b1; cyc(4);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; cyc(4);
    scl_m = 1'b1; cyc(4);
    scl_m = 1'b0; cyc(4);
  endtask

  // 8 bits, sample oe, then ninth clock with master released
  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    ack_seen = sda_oe;
    bit_out(1'b1);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic addressed;
    cyc(3); 
    // R1 reset state
    rd(1'b0, r); chk("R1 ctrl", r, 8'h00);
    rd(1'b1, r); chk("R1 own", r, 8'h00);
    chk("R1 irq/oe", {6'b0, irq, sda_oe}, 8'h00);
    rst_n = 1'b1; cyc(2);
    rd(1'b0, r); chk("R1 ctrl after release", r, 8'h00);

    // R2 register access
    wr(1'b0, 8'hFF); rd(1'b0, r); chk("R2 ro bits", r, 8'hE0);
    wr(1'b1, 8'hA5); rd(1'b1, r); chk("R2 own rw", r, 8'hA5);

    // table walk: R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < 8; v++) begin
      wr(1'b1, VEC[v][19:12]);
      wr(1'b0, {VEC[v][11], 2'b11, 5'b0});
      bus_start();
      rd(1'b0, r); chk("R3 busy after start", {7'b0, r[2]}, 8'h01);
      byte_out(VEC[v][10:3]);
      addressed = VEC[v][2] | (VEC[v][1] & VEC[v][11]);
      chk("R7 R11 ack drive", {7'b0, ack_seen}, {7'b0, VEC[v][0]});
      rd(1'b0, r);
      chk("R4 match", {7'b0, r[1]}, {7'b0, VEC[v][2]});
      chk("R5 general call", {7'b0, r[4]}, {7'b0, VEC[v][1]});
      chk("R6 direction", {7'b0, r[3]}, {7'b0, addressed & VEC[v][3]});
      if (addressed) chk("R8 last bit", {7'b0, r[0]}, {7'b0, ~VEC[v][0]});
      chk("R9 R11 intf", {7'b0, intf}, {7'b0, addressed});
      bus_stop();
      rd(1'b0, r); chk("R3 R4 R5 stop clears", {5'b0, r[4], r[2], r[1]}, 8'h00);
    end

    // R2 writes leave flag bits alone (lrb currently 0)
    rd(1'b0, r);
    wr(1'b0, 8'h7F); rd(1'b0, r); chk("R2 write keeps flags", r, 8'h60);

    // receive data byte: ACK, lrb 0, intf R7 R8 R9
    wr(1'b1, 8'h42); wr(1'b0, 8'hE0);
    bus_start(); byte_out(8'h84);
    wr(1'b0, 8'hE0);
    chk("R9 write clears intf", {7'b0, intf}, 8'h00);
    byte_out(8'h5A);
    chk("R7 data ack", {7'b0, ack_seen}, 8'h01);
    rd(1'b0, r); chk("R8 data lrb", {7'b0, r[0]}, 8'h00);
    chk("R9 data intf", {7'b0, intf}, 8'h01);
    gate = 1'b0; cyc(1); chk("R9 irq gated", {7'b0, irq}, 8'h00);
    gate = 1'b1; cyc(1); chk("R9 irq on", {7'b0, irq}, 8'h01);
    bus_stop();

    // transmit direction: no slave ack, master NACK seen R6 R7 R8
    wr(1'b0, 8'hE0);
    bus_start(); byte_out(8'h85);
    rd(1'b0, r); chk("R6 tx mode", {7'b0, r[3]}, 8'h01);
    byte_out(8'h33);
    chk("R7 no ack in tx", {7'b0, ack_seen}, 8'h00);
    rd(1'b0, r); chk("R8 nack lrb", {7'b0, r[0]}, 8'h01);
    bus_stop();

    // unaddressed: data ignored R11
    wr(1'b0, 8'hE0);
    bus_start(); byte_out(8'h86); byte_out(8'h00);
    chk("R11 no ack on data", {7'b0, ack_seen}, 8'h00);
    chk("R11 no intf", {7'b0, intf}, 8'h00);
    bus_stop();

    // interrupt flag enable off R9
    wr(1'b0, 8'hC0);
    bus_start(); byte_out(8'h84);
    chk("R9 ien off ack still", {7'b0, ack_seen}, 8'h01);
    chk("R9 ien off no intf", {7'b0, intf}, 8'h00);
    chk("R9 ien off no irq", {7'b0, irq}, 8'h00);
    bus_stop();

    // module disabled R10
    wr(1'b0, 8'hA0);
    bus_start();
    rd(1'b0, r); chk("R10 busy stays 0", {7'b0, r[2]}, 8'h00);
    byte_out(8'h84);
    chk("R10 no ack", {7'b0, ack_seen}, 8'h00);
    rd(1'b0, r); chk("R10 no match", {7'b0, r[1]}, 8'h00);
    bus_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule